// File: doc/BRIEF.md
# Dual-Clock FIFO With Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and read side each run on their own clock. The two clocks may be one shared clock or may have no phase or frequency relation at all. A word enters when both write enables are high on a write-clock edge. A word leaves when both read enables are high on a read-clock edge. Each read loads the oldest stored word into an output register.

The block reports its level on four flags. Empty and Full are fixed. Almost-Empty and Almost-Full compare the fill level, or the free space, against two programmable thresholds. Each threshold is 18 bits wide and is stored as a low half and a high half. A short write-side sequence loads the four halves one after another from the data bus.

Pointers cross between the clock domains as Gray codes. Each domain computes its own flags from its local pointer and the synchronized pointer of the other side. An output-enable input gates both the presented data and a data-valid indication.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: A word is stored on a rising `wrClk` edge only when `wrEn1` and `wrEn2` are both 1, `loadEn` is 0 and `full` is 0. With either write enable at 0, nothing is stored.
- R2: A read happens on a rising `rdClk` edge only when `rdEn1` and `rdEn2` are both 1 and `empty` is 0. That edge loads the oldest word into the output register. Otherwise the output register holds its value.
- R3: Words come out in the order they were written, with no loss and no duplication, both with one shared clock and with unrelated write and read clocks.
- R4: `empty` is 1 when the read side sees no stored word. `full` is 1 when the write side sees DEPTH stored words. With one shared clock, a write to an empty buffer clears `empty` two edges after the writing edge. Likewise, a read from a full buffer clears `full` two edges after the reading edge.
- R5: A write attempt while `full` is 1 and a read attempt while `empty` is 1 are ignored. The pointers, the stored words and the output register stay unchanged.
- R6: `almostEmpty` is 1 when the read-side fill level is at or below the Almost-Empty threshold. `almostFull` is 1 when the write-side free space is at or below the Almost-Full threshold.
- R7: While `loadEn`, `wrEn1` and `wrEn2` are all 1, each `wrClk` edge writes `wrData` into one threshold part and stores no word. The parts are taken in a fixed order, then the order wraps back to the first part:
  - Almost-Empty bits 8:0
  - Almost-Empty bits 17:9
  - Almost-Full bits 8:0
  - Almost-Full bits 17:9
- R8: With `outEn` at 0, `rdData` is 0 and `rdValid` is 0. With `outEn` at 1, `rdData` shows the output register, and `rdValid` is 1 once a read has happened since reset.
- R9: An active-low asynchronous `rstN` puts the block into its initial state:
  - both pointers cleared, so `empty` is 1 and `full` is 0
  - the output register cleared to 0
  - both thresholds set to 7
  - the load sequence returned to its first part

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 9 | Write word, or threshold part during a load |
| wrEn1 | input | 1 | First write enable |
| wrEn2 | input | 1 | Second write enable |
| loadEn | input | 1 | Routes write cycles to the threshold registers |
| rdEn1 | input | 1 | First read enable |
| rdEn2 | input | 1 | Second read enable |
| outEn | input | 1 | Output enable for `rdData` and `rdValid` |
| rdData | output | 9 | Output register, gated by `outEn` |
| rdValid | output | 1 | Output holds a read word and `outEn` is 1 |
| empty | output | 1 | No word visible to the read side |
| full | output | 1 | DEPTH words seen by the write side |
| almostEmpty | output | 1 | Fill level at or below the Almost-Empty threshold |
| almostFull | output | 1 | Free space at or below the Almost-Full threshold |

## Verification
A corrupted pointer or synchronizer stage shows at the ports within a few cycles. The flags disagree with the expected fill level, or `rdData` returns a word out of order on the next read. With a shared clock, every output is compared on every cycle against a behavioural model that carries the two-stage synchronizer delay. A flag that moves one edge early or late is therefore seen at that very cycle. A threshold part written to the wrong slot shows as soon as the fill level crosses the intended boundary.

// File: rtl/fifo_flag_pkg.sv
`timescale 1ns/1ps
package fifo_flag_pkg;
  localparam int DATA_W = 9;
  localparam int THR_W  = 2 * DATA_W;

  typedef enum logic [1:0] {
    LD_AE_LO = 2'd0,
    LD_AE_HI = 2'd1,
    LD_AF_LO = 2'd2,
    LD_AF_HI = 2'd3
  } ldStep_e;

  typedef struct packed {
    logic    wrDo;
    logic    rdDo;
    logic    ldDo;
    ldStep_e ldSel;
  } strobes_t;
endpackage

// File: rtl/fifo_flag_sync.sv
`timescale 1ns/1ps
module fifo_flag_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/fifo_flag_ctrl.sv
`timescale 1ns/1ps
module fifo_flag_ctrl
  import fifo_flag_pkg::*;
#(
  parameter  int DEPTH       = 1024,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(DEPTH),
  localparam int PTR_W       = ADDR_W + 1,
  localparam int CMP_W       = (THR_W > PTR_W + 1) ? THR_W : PTR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn1,
  input  logic              wrEn2,
  input  logic              loadEn,
  input  logic              rdEn1,
  input  logic              rdEn2,
  input  logic [THR_W-1:0]  aeThresh,
  input  logic [THR_W-1:0]  afThresh,
  output strobes_t          strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              empty,
  output logic              full,
  output logic              almostEmpty,
  output logic              almostFull
);
  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wrPtr, wrGray, rdPtr, rdGray;
  logic [PTR_W-1:0] rdGrayAtWr, wrGrayAtRd;
  logic [PTR_W-1:0] wrFill, wrFree, rdFill;
  ldStep_e          ldStep;
  logic             wrReq;

  fifo_flag_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk(wrClk), .rstN(rstN), .din(rdGray), .dout(rdGrayAtWr));
  fifo_flag_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGrayAtRd));

  // write-domain level and flags
  assign wrFill     = wrPtr - fromGray(rdGrayAtWr);
  assign wrFree     = PTR_W'(DEPTH) - wrFill;
  assign full       = (wrFill == PTR_W'(DEPTH));
  assign almostFull = (CMP_W'(wrFree) <= CMP_W'(afThresh));

  // read-domain level and flags
  assign rdFill      = fromGray(wrGrayAtRd) - rdPtr;
  assign empty       = (rdFill == '0);
  assign almostEmpty = (CMP_W'(rdFill) <= CMP_W'(aeThresh));

  assign wrReq      = wrEn1 & wrEn2;
  assign strb.wrDo  = wrReq & ~loadEn & ~full;
  assign strb.ldDo  = wrReq & loadEn;
  assign strb.ldSel = ldStep;
  assign strb.rdDo  = rdEn1 & rdEn2 & ~empty;

  assign wrAddr = wrPtr[ADDR_W-1:0];
  assign rdAddr = rdPtr[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
      ldStep <= LD_AE_LO;
    end else begin
      if (strb.wrDo) begin
        wrPtr  <= wrPtr + 1'b1;
        wrGray <= toGray(wrPtr + 1'b1);
      end
      if (strb.ldDo) ldStep <= ldStep_e'(ldStep + 2'd1);
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      rdGray <= '0;
    end else if (strb.rdDo) begin
      rdPtr  <= rdPtr + 1'b1;
      rdGray <= toGray(rdPtr + 1'b1);
    end
  end
endmodule

// File: rtl/fifo_flag_dpath.sv
`timescale 1ns/1ps
module fifo_flag_dpath
  import fifo_flag_pkg::*;
#(
  parameter  int DEPTH      = 1024,
  parameter  int DEF_OFFSET = 7,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int PARTS      = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] outWord,
  output logic              haveData,
  output logic [THR_W-1:0]  aeThresh,
  output logic [THR_W-1:0]  afThresh
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrDo) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      outWord  <= '0;
      haveData <= 1'b0;
    end else if (strb.rdDo) begin
      outWord  <= mem[rdAddr];
      haveData <= 1'b1;
    end
  end

  // one register per threshold part; even parts are low halves
  for (genvar p = 0; p < PARTS; p++) begin : g_thr
    localparam logic [DATA_W-1:0] RST_VAL =
      (p % 2 == 0) ? DATA_W'(DEF_OFFSET) : '0;
    logic [DATA_W-1:0] q;
    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN) q <= RST_VAL;
      else if (strb.ldDo && strb.ldSel == ldStep_e'(p)) q <= wrData;
    end
  end

  assign aeThresh = {g_thr[1].q, g_thr[0].q};
  assign afThresh = {g_thr[3].q, g_thr[2].q};
endmodule

// File: rtl/dual_clock_flag_fifo.sv
`timescale 1ns/1ps
module dual_clock_flag_fifo
  import fifo_flag_pkg::*;
#(
  parameter  int DEPTH       = 1024,
  parameter  int SYNC_STAGES = 2,
  parameter  int DEF_OFFSET  = 7,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn1,
  input  logic              wrEn2,
  input  logic              loadEn,
  input  logic              rdEn1,
  input  logic              rdEn2,
  input  logic              outEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              empty,
  output logic              full,
  output logic              almostEmpty,
  output logic              almostFull
);
  strobes_t          strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [THR_W-1:0]  aeThresh, afThresh;
  logic [DATA_W-1:0] outWord;
  logic              haveData;

  fifo_flag_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn1(wrEn1), .wrEn2(wrEn2), .loadEn(loadEn),
    .rdEn1(rdEn1), .rdEn2(rdEn2),
    .aeThresh(aeThresh), .afThresh(afThresh),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .empty(empty), .full(full),
    .almostEmpty(almostEmpty), .almostFull(almostFull));

  fifo_flag_dpath #(.DEPTH(DEPTH), .DEF_OFFSET(DEF_OFFSET)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .outWord(outWord), .haveData(haveData),
    .aeThresh(aeThresh), .afThresh(afThresh));

  assign rdData  = outEn ? outWord : '0;
  assign rdValid = outEn & haveData;
endmodule

// File: rtl/fifo_flag_checker.sv
`timescale 1ns/1ps
module fifo_flag_checker #(
  parameter  int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEn1,
  input logic              wrEn2,
  input logic              loadEn,
  input logic              rdEn1,
  input logic              rdEn2,
  input logic              outEn,
  input logic [8:0]        rdData,
  input logic              rdValid,
  input logic              empty,
  input logic              full,
  input logic              almostEmpty,
  input logic              almostFull,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [8:0]        outWord
);
  assert_single_enable_write_R1: assert property (@(posedge wrClk) disable iff (!rstN)
    !(wrEn1 && wrEn2) |=> $stable(wrAddr));

  assert_hold_output_R2: assert property (@(posedge rdClk) disable iff (!rstN)
    !(rdEn1 && rdEn2) |=> $stable(outWord));

  assert_read_step_R2: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn1 && rdEn2 && !empty) |=> (rdAddr == ADDR_W'($past(rdAddr) + 1'b1)));

  assert_no_overflow_R5: assert property (@(posedge wrClk) disable iff (!rstN)
    (full && wrEn1 && wrEn2 && !loadEn) |=> $stable(wrAddr));

  assert_no_underflow_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    (empty && rdEn1 && rdEn2) |=> ($stable(rdAddr) && $stable(outWord)));

  assert_full_implies_af_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> almostFull);

  assert_empty_implies_ae_R6: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> almostEmpty);

  assert_load_no_store_R7: assert property (@(posedge wrClk) disable iff (!rstN)
    (loadEn && wrEn1 && wrEn2) |=> $stable(wrAddr));

  assert_oe_gate_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    !outEn |-> (rdData == 9'd0 && !rdValid));
endmodule

bind dual_clock_flag_fifo fifo_flag_checker #(.DEPTH(DEPTH)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEn1(wrEn1), .wrEn2(wrEn2), .loadEn(loadEn),
  .rdEn1(rdEn1), .rdEn2(rdEn2), .outEn(outEn),
  .rdData(rdData), .rdValid(rdValid), .empty(empty), .full(full),
  .almostEmpty(almostEmpty), .almostFull(almostFull),
  .wrAddr(wrAddr), .rdAddr(rdAddr), .outWord(outWord));

// File: tb/dual_clock_flag_fifo_bench.sv
`timescale 1ns/1ps
module dual_clock_flag_fifo_bench;
  localparam int DEPTH = 32;

  logic clkA = 1'b0, clkB = 1'b0, asyncMode = 1'b0;
  logic rdClk;
  always #2.5 clkA = ~clkA;
  always #3.5 clkB = ~clkB;
  assign rdClk = asyncMode ? clkB : clkA;

  logic       rstN = 1'b0;
  logic [8:0] wrData = '0;
  logic       wrEn1 = 0, wrEn2 = 0, loadEn = 0, rdEn1 = 0, rdEn2 = 0, outEn = 1;
  logic [8:0] rdData;
  logic       rdValid, empty, full, almostEmpty, almostFull;

  dual_clock_flag_fifo #(.DEPTH(DEPTH)) u_dual_clock_flag_fifo (
    .wrClk(clkA), .rdClk(rdClk), .rstN(rstN), .wrData(wrData),
    .wrEn1(wrEn1), .wrEn2(wrEn2), .loadEn(loadEn),
    .rdEn1(rdEn1), .rdEn2(rdEn2), .outEn(outEn),
    .rdData(rdData), .rdValid(rdValid), .empty(empty), .full(full),
    .almostEmpty(almostEmpty), .almostFull(almostFull));

  int    nChecks = 0, nBad = 0;
  bit    finished = 0;
  string curReq = "R9";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model, shared-clock mode only
  int         mWr, mRd, mWs1, mWs2, mRs1, mRs2, mStep;
  int         mThr [4];
  logic [8:0] mMem [DEPTH];
  logic [8:0] mOut;
  bit         mHave;

  always @(posedge clkA) begin
    bit doW, doL, doR;
    if (!asyncMode) begin
      if (!rstN) begin
        mWr = 0; mRd = 0; mWs1 = 0; mWs2 = 0; mRs1 = 0; mRs2 = 0; mStep = 0;
        mThr[0] = 7; mThr[1] = 0; mThr[2] = 7; mThr[3] = 0;
        mOut = '0; mHave = 0;
      end else begin
        doW = wrEn1 && wrEn2 && !loadEn && ((mWr - mRs2) != DEPTH);
        doL = wrEn1 && wrEn2 && loadEn;
        doR = rdEn1 && rdEn2 && (mWs2 != mRd);
        if (doR) begin mOut = mMem[mRd % DEPTH]; mHave = 1; end
        if (doW) mMem[mWr % DEPTH] = wrData;
        if (doL) begin mThr[mStep] = int'(wrData); mStep = (mStep + 1) % 4; end
        mWs2 = mWs1; mRs2 = mRs1; mWs1 = mWr; mRs1 = mRd;
        if (doW) mWr++;
        if (doR) mRd++;
      end
    end
  end

  always @(negedge clkA) begin
    int aeT, afT, expData;
    if (!asyncMode && rstN && !finished) begin
      aeT = mThr[1] * 512 + mThr[0];
      afT = mThr[3] * 512 + mThr[2];
      expData = outEn ? int'(mOut) : 0;
      check(empty == (mWs2 == mRd), curReq, "empty", int'(empty), int'(mWs2 == mRd));
      check(full == ((mWr - mRs2) == DEPTH), curReq, "full", int'(full),
            int'((mWr - mRs2) == DEPTH));
      check(almostEmpty == ((mWs2 - mRd) <= aeT), curReq, "almostEmpty",
            int'(almostEmpty), int'((mWs2 - mRd) <= aeT));
      check(almostFull == ((DEPTH - (mWr - mRs2)) <= afT), curReq, "almostFull",
            int'(almostFull), int'((DEPTH - (mWr - mRs2)) <= afT));
      check(int'(rdData) == expData, curReq, "rdData", int'(rdData), expData);
      check(rdValid == (outEn && mHave), curReq, "rdValid", int'(rdValid),
            int'(outEn && mHave));
    end
  end

  task automatic cyc(input bit w1, input bit w2, input bit ld, input int d,
                     input bit r1, input bit r2);
    @(negedge clkA);
    wrEn1 = w1; wrEn2 = w2; loadEn = ld; wrData = 9'(d); rdEn1 = r1; rdEn2 = r2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clkA); rstN = 0;
    wrEn1 = 0; wrEn2 = 0; loadEn = 0; rdEn1 = 0; rdEn2 = 0;
    repeat (3) @(posedge clkA);
    @(negedge clkA); rstN = 1;
  endtask

  // unrelated-clock scoreboard
  logic [8:0] sbq [$];

  task automatic asyncWriter(input int n);
    for (int i = 0; i < n; i++) begin
      bit w;
      @(negedge clkA);
      w = ($urandom % 3) != 0;
      wrData = 9'($urandom);
      wrEn1 = w; wrEn2 = w;
      if (w && !full) sbq.push_back(wrData);
    end
    @(negedge clkA); wrEn1 = 0; wrEn2 = 0;
  endtask

  task automatic asyncReader(input int n);
    bit pend = 0;
    logic [8:0] exp = '0;
    for (int i = 0; i < n; i++) begin
      bit r;
      @(negedge clkB);
      if (pend) check(rdData == exp, "R3", "async rdData", int'(rdData), int'(exp));
      r = (i < n - 40) ? (($urandom % 2) != 0) : 1'b1;
      rdEn1 = r; rdEn2 = r;
      pend = r && !empty;
      if (pend) exp = sbq.pop_front();
    end
    @(negedge clkB); rdEn1 = 0; rdEn2 = 0;
    if (pend) check(rdData == exp, "R3", "async rdData", int'(rdData), int'(exp));
  endtask

  initial begin
    doReset();
    // reset state
    check(empty == 1, "R9", "empty after reset", int'(empty), 1);
    check(full == 0, "R9", "full after reset", int'(full), 0);
    check(almostEmpty == 1 && almostFull == 0, "R9", "ae/af after reset",
          int'({almostEmpty, almostFull}), 2);
    check(rdData == 0 && rdValid == 0, "R9", "output after reset",
          int'(rdData), 0);

    curReq = "R1";
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, 'h1a, 0, 0);
      cyc(0, 1, 0, 'h1b, 0, 0);
    end
    idle(3);
    check(empty == 1, "R1", "single enable stored nothing", int'(empty), 1);

    curReq = "R4";
    cyc(1, 1, 0, 'h155, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    check(empty == 1, "R4", "empty one edge after write", int'(empty), 1);
    cyc(0, 0, 0, 0, 0, 0);
    check(empty == 1, "R4", "empty two edges... first sync", int'(empty), 1);
    cyc(0, 0, 0, 0, 0, 0);
    check(empty == 0, "R4", "empty clears after sync", int'(empty), 0);

    curReq = "R1";
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 'h100 + i, 0, 0);
    idle(3);

    curReq = "R2";
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    idle(1);
    check(rdValid == 0, "R2", "no read with single enable", int'(rdValid), 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, (i != 2));
    idle(3);
    check(rdData == 9'h103, "R2", "fifth word held", int'(rdData), 'h103);

    curReq = "R5";
    for (int i = 0; i < 40; i++) cyc(1, 1, 0, i, 0, 0);
    idle(3);
    check(full == 1, "R5", "full after overfill", int'(full), 1);
    curReq = "R6";
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 1, 1);
    idle(3);
    check(empty == 1, "R5", "empty after overdrain", int'(empty), 1);

    curReq = "R7";
    cyc(1, 1, 1, 3, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    cyc(1, 1, 1, 5, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    cyc(1, 1, 1, 2, 0, 0);
    idle(3);
    check(empty == 1, "R7", "load stored no word", int'(empty), 1);
    for (int i = 0; i < 34; i++) cyc(1, 1, 0, 'h80 + i, 0, 0);
    idle(3);
    for (int i = 0; i < 34; i++) cyc(0, 0, 0, 0, 1, 1);
    idle(3);
    cyc(1, 1, 1, 1, 0, 0);
    idle(1);
    for (int i = 0; i < 12; i++) cyc(1, 1, 0, i, 0, 0);
    idle(3);
    check(almostEmpty == 1, "R7", "high part raises AE threshold", int'(almostEmpty), 1);

    curReq = "R8";
    outEn = 0;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1);
    idle(1);
    check(rdData == 0 && rdValid == 0, "R8", "outEn low gates output", int'(rdData), 0);
    outEn = 1;
    idle(1);
    check(rdValid == 1, "R8", "valid after read with outEn", int'(rdValid), 1);

    curReq = "R3";
    for (int i = 0; i < 300; i++)
      cyc(($urandom % 3) != 0, 1, 0, $urandom % 512, ($urandom % 2) != 0, 1);
    idle(3);

    doReset();
    curReq = "R9";
    check(empty == 1, "R9", "empty after mid-run reset", int'(empty), 1);
    for (int i = 0; i < 7; i++) cyc(1, 1, 0, i, 0, 0);
    idle(3);
    check(almostEmpty == 1, "R9", "AE threshold back to 7 at fill 7", int'(almostEmpty), 1);
    cyc(1, 1, 0, 7, 0, 0);
    idle(3);
    check(almostEmpty == 0, "R9", "AE clear at fill 8", int'(almostEmpty), 0);
    cyc(1, 1, 1, 20, 0, 0);
    idle(2);
    check(almostEmpty == 1, "R9", "load restarted at first part", int'(almostEmpty), 1);

    // unrelated clocks
    @(negedge clkA); rstN = 0; asyncMode = 1;
    repeat (4) @(posedge clkA);
    @(negedge clkA); rstN = 1;
    fork
      asyncWriter(400);
      asyncReader(700);
    join
    check(sbq.size() == 0, "R3", "async scoreboard drained", sbq.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    #900us;
    if (!finished) begin
      finished = 1;
      nChecks++; nBad++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule